// File: doc/BRIEF.md
# Unaligned Word Read Bus Sequencer

This block connects a CPU-side load port to a memory that is organised as 16-bit words. The CPU side asks for one byte or one 16-bit word at any 20-bit byte address. The block turns each request into one or two accesses on the memory side. The memory side takes a 19-bit word address made from the upper nineteen bits of the byte address. Bit 0 of the byte address never leaves the block. It only chooses which byte lane is used.

A word read at an even byte address uses one access, and both bytes come from the same memory word. A word read at an odd byte address uses two accesses in a row. The first access fetches the word that holds the requested low byte, and that word's upper lane is kept in a holding register. The second access fetches the following word, and its lower lane becomes the upper byte of the result. The assembled word is returned only after the second access completes. A byte read returns the selected lane on the low eight result bits, with the upper eight bits cleared.

Only one request is in flight at a time. The response is a one-cycle pulse that carries the data and the number of memory accesses the transaction used.

Top module: `unaligned_read_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0. While `req_ready` is 1, `mem_req` is 0.
- R2: A word read (`req_size`=1) at an even byte address A issues exactly one memory access, with `mem_addr` = A[19:1], and returns `rsp_data` equal to the full memory word.
- R3: A word read at an odd byte address A issues exactly two accesses on consecutive cycles, to A[19:1] and then to A[19:1]+1. It returns `rsp_data[7:0]` = the first word's bits [15:8] and `rsp_data[15:8]` = the second word's bits [7:0].
- R4: For an odd word read at byte address 0xFFFFF, the second word address wraps to 0.
- R5: A byte read (`req_size`=0) at an even address uses one access and returns {8'h00, word[7:0]}.
- R6: A byte read at an odd address uses one access and returns {8'h00, word[15:8]}, which moves the upper lane onto the low result bits.
- R7: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the response has been delivered. `rsp_valid` is high for exactly one cycle per request.
- R8: Memory read data arrives on the cycle after each `mem_req`. For a single-access transaction, `rsp_valid` is high in the second cycle after the accepting edge. For a two-access transaction, it is high in the third cycle. `mem_req` is 0 while `rsp_valid` is 1.
- R9: While `rsp_valid` is 1, `rsp_nacc` gives the number of memory accesses the transaction used: 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_addr | input | 20 | Byte address of the read |
| req_size | input | 1 | 0 = byte, 1 = word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 16 | Result data, valid with rsp_valid |
| rsp_nacc | output | 2 | Memory accesses used by this transaction |
| mem_req | output | 1 | Memory read access this cycle |
| mem_addr | output | 19 | Word address of the access |
| mem_rdata | input | 16 | Memory word, returned the cycle after mem_req |

## Verification
A sequencer that is stuck or skips a state shows at the ports within one or two cycles. The strobe arrives one cycle early or late, `mem_req` pulses the wrong number of times, or `req_ready` stays low for good. A holding register that captures on the wrong cycle, or a lane select driven by the wrong address bit, leaves the handshake looking normal. It corrupts only the byte order of `rsp_data` on the response cycle of odd-address reads. For that reason every odd-address scenario compares the data against a bench memory model. The wrap case checks the second `mem_addr` at the top address.

// File: rtl/ur_pkg.sv
package ur_pkg;

    localparam int UR_ADDR_W = 20;
    localparam int UR_DATA_W = 16;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_RESP   = 2'd3
    } state_e;

    // What kind of read is in flight: lane parity and access size.
    typedef struct packed {
        logic  odd;
        size_e size;
    } kind_t;

    function automatic logic needs_two(kind_t k);
        return k.odd && (k.size == SZ_WORD);
    endfunction

endpackage

// File: rtl/ur_ctrl.sv
module ur_ctrl
    import ur_pkg::*;
#(
    parameter int NACC_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  kind_t             kind_in,
    output logic              req_ready,
    output logic              accept,
    output kind_t             kind_q,
    output logic              mem_req,
    output logic              second,
    output logic              capture,
    output logic              rsp_valid,
    output logic [NACC_W-1:0] rsp_nacc
);

    state_e            state_q, state_d;
    logic [NACC_W-1:0] nacc_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign mem_req   = (state_q == ST_FIRST) || (state_q == ST_SECOND);
    assign second    = (state_q == ST_SECOND);
    assign capture   = (state_q == ST_SECOND);
    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_nacc  = nacc_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_FIRST;
            ST_FIRST:  state_d = needs_two(kind_q) ? ST_SECOND : ST_RESP;
            ST_SECOND: state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= '{odd: 1'b0, size: SZ_BYTE};
            nacc_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q <= kind_in;
                nacc_q <= '0;
            end else if (mem_req) begin
                nacc_q <= nacc_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ur_addr_gen.sv
module ur_addr_gen #(
    parameter int ADDR_W = 20,
    localparam int WA_W  = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              second,
    output logic [WA_W-1:0]   mem_addr
);

    logic [WA_W-1:0] waddr_q;

    always_ff @(posedge clk) begin
        if (rst)         waddr_q <= '0;
        else if (accept) waddr_q <= req_addr[ADDR_W-1:1];
    end

    // The increment is modulo the word space, so the top word wraps to 0.
    assign mem_addr = second ? waddr_q + {{(WA_W-1){1'b0}}, 1'b1} : waddr_q;

endmodule

// File: rtl/ur_lane.sv
module ur_lane
    import ur_pkg::*;
#(
    parameter int DATA_W  = 16,
    localparam int LANE_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  kind_t             kind,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rsp_data
);

    logic [LANE_W-1:0] hold_q;
    logic [LANE_W-1:0] lo_lane, hi_lane;

    assign lo_lane = mem_rdata[LANE_W-1:0];
    assign hi_lane = mem_rdata[DATA_W-1:LANE_W];

    always_ff @(posedge clk) begin
        if (rst)          hold_q <= '0;
        else if (capture) hold_q <= hi_lane;
    end

    always_comb begin
        unique case ({kind.size, kind.odd})
            {SZ_BYTE, 1'b0}: rsp_data = {{LANE_W{1'b0}}, lo_lane};
            {SZ_BYTE, 1'b1}: rsp_data = {{LANE_W{1'b0}}, hi_lane};
            {SZ_WORD, 1'b0}: rsp_data = mem_rdata;
            default:         rsp_data = {lo_lane, hold_q};
        endcase
    end

endmodule

// File: rtl/unaligned_read_seq.sv
module unaligned_read_seq
    import ur_pkg::*;
#(
    parameter int ADDR_W  = UR_ADDR_W,
    parameter int DATA_W  = UR_DATA_W,
    localparam int WA_W   = ADDR_W - 1,
    localparam int NACC_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_size,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [NACC_W-1:0] rsp_nacc,
    output logic              mem_req,
    output logic [WA_W-1:0]   mem_addr,
    input  logic [DATA_W-1:0] mem_rdata
);

    kind_t kind_in, kind_q;
    logic  accept, second, capture;

    assign kind_in = '{odd: req_addr[0], size: size_e'(req_size)};

    ur_ctrl #(.NACC_W(NACC_W)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .kind_in   (kind_in),
        .req_ready (req_ready),
        .accept    (accept),
        .kind_q    (kind_q),
        .mem_req   (mem_req),
        .second    (second),
        .capture   (capture),
        .rsp_valid (rsp_valid),
        .rsp_nacc  (rsp_nacc)
    );

    ur_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .req_addr (req_addr),
        .second   (second),
        .mem_addr (mem_addr)
    );

    ur_lane #(.DATA_W(DATA_W)) i_lane (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .kind      (kind_q),
        .mem_rdata (mem_rdata),
        .rsp_data  (rsp_data)
    );

endmodule

// File: rtl/ur_checker.sv
module ur_checker #(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 16,
    localparam int WA_W   = ADDR_W - 1,
    localparam int NACC_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [NACC_W-1:0] rsp_nacc,
    input logic              mem_req,
    input logic [WA_W-1:0]   mem_addr
);

    // R1: an idle sequencer never drives the memory.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req);

    // R3: back-to-back accesses address consecutive words (R4: modulo the word space).
    assert_second_word_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + {{(WA_W-1){1'b0}}, 1'b1}));

    // R7: accepting a request makes the block busy on the next cycle.
    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R7: the response is a single-cycle pulse.
    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R8: no memory access is in progress during the response cycle.
    assert_no_req_in_resp_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !mem_req);

    // R9: the reported access count is one or two.
    assert_nacc_range_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_nacc == 2'd1 || rsp_nacc == 2'd2));

endmodule

bind unaligned_read_seq ur_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ur_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_nacc  (rsp_nacc),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr)
);

// File: tb/test_unaligned_read_seq.sv
`timescale 1ns/1ps
module test_unaligned_read_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [19:0] req_addr;
    logic        req_size;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [1:0]  rsp_nacc;
    logic        mem_req;
    logic [18:0] mem_addr;
    logic [15:0] mem_rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    unaligned_read_seq i_unaligned_read_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_nacc(rsp_nacc),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    // Word memory model: the two halves of most words differ.
    function automatic logic [15:0] model(input logic [18:0] w);
        logic [2:0] t;
        t = w[18:16];
        return w[15:0] ^ {t, t, t, t, t, 1'b1};
    endfunction

    always @(posedge clk) begin
        if (mem_req) mem_rdata <= model(mem_addr);
        else         mem_rdata <= 16'hDEAD;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One read transaction; checks addresses, access count, latency and data.
    task automatic do_read(input logic [19:0] a, input bit word, input string tag);
        logic [18:0] w0;
        logic [15:0] exp;
        int          exp_n, seen_n, lat;
        logic [18:0] seen_a[2];
        w0     = a[19:1];
        exp_n  = (word && a[0]) ? 2 : 1;
        if (!word)      exp = a[0] ? {8'h00, model(w0)[15:8]} : {8'h00, model(w0)[7:0]};
        else if (!a[0]) exp = model(w0);
        else            exp = {model(w0 + 19'd1)[7:0], model(w0)[15:8]};
        seen_n = 0;
        lat    = 0;
        @(negedge clk);
        chk(req_ready === 1'b1, {tag, " R7 ready before request"}, req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_size = word;
        @(negedge clk);
        req_valid = 1'b0; req_addr = 20'h0; req_size = 1'b0;
        lat = 1;
        chk(req_ready === 1'b0, {tag, " R7 busy after accept"}, req_ready, 0);
        while (!rsp_valid && lat < 8) begin
            if (mem_req) begin
                if (seen_n < 2) seen_a[seen_n] = mem_addr;
                seen_n++;
            end
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_n + 1, {tag, " R8 latency"}, lat, exp_n + 1);
        chk(seen_n == exp_n, {tag, " R2/R3 access count"}, seen_n, exp_n);
        chk(rsp_nacc == 2'(exp_n), {tag, " R9 reported count"}, rsp_nacc, exp_n);
        chk(seen_n < 1 || seen_a[0] == w0, {tag, " R2 first word address"}, seen_a[0], w0);
        if (exp_n == 2)
            chk(seen_n < 2 || seen_a[1] == w0 + 19'd1, {tag, " R3 second word address"},
                seen_a[1], w0 + 19'd1);
        chk(rsp_data === exp, {tag, " data"}, rsp_data, exp);
        @(negedge clk);
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, {tag, " R7 single pulse"},
            {rsp_valid, req_ready}, 2'b01);
    endtask

    task automatic test_reset();
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 reset ready", req_ready, 1);
        chk(rsp_valid === 1'b0, "R1 reset rsp_valid", rsp_valid, 0);
        chk(mem_req === 1'b0, "R1 reset mem_req", mem_req, 0);
    endtask

    task automatic test_even_words();
        do_read(20'h01234, 1'b1, "R2 even word");
        do_read(20'hFFFFE, 1'b1, "R2 even word top");
        do_read(20'h00000, 1'b1, "R2 even word zero");
    endtask

    task automatic test_odd_words();
        do_read(20'h01235, 1'b1, "R3 odd word");
        do_read(20'h0FFFF, 1'b1, "R3 odd word carry");
        do_read(20'h5A5A7, 1'b1, "R3 odd word pattern");
    endtask

    task automatic test_wrap();
        do_read(20'hFFFFF, 1'b1, "R4 wrap");
    endtask

    task automatic test_bytes();
        do_read(20'h00A40, 1'b0, "R5 even byte");
        do_read(20'h3C3C2, 1'b0, "R5 even byte pattern");
        do_read(20'h00A41, 1'b0, "R6 odd byte");
        do_read(20'hFFFFF, 1'b0, "R6 odd byte top");
    endtask

    task automatic test_mixed_sequence();
        do_read(20'h12345, 1'b1, "R3 mix odd word");
        do_read(20'h12346, 1'b1, "R2 mix even word");
        do_read(20'h12347, 1'b0, "R6 mix odd byte");
        do_read(20'h12347, 1'b1, "R3 mix odd word again");
    endtask

    initial begin
        test_reset();
        test_even_words();
        test_odd_words();
        test_wrap();
        test_bytes();
        test_mixed_sequence();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule